// File: doc/BRIEF.md
# Non-volatile array program and erase sequencer

This block drives the strobe-level control pins of a non-volatile memory array through byte programming and whole-array erase. A host requests an operation with a one-cycle start pulse and a mode bit. In program mode it then supplies bytes with their addresses over a valid/ready stream. The sequencer raises the mode select, turns on the high-voltage enable, emits one write strobe per byte and shuts everything down in order. Every minimum gap between these steps is counted in clock cycles, derived from a cycles-per-microsecond parameter and a set of microsecond parameters.

The block also guards the array against wear. It keeps a two-bit program count for every address and a program-time total for every row. A byte that would be written a third time, or that would push its row past the time budget, is refused and sets the violation flag. A byte outside the row of the first byte in the window ends the window and sets the row error flag. A completed erase clears all the counts and totals.

Top module: `flash_pe_seq`

## Requirements
- R1: The selected mode line (`arr_sel_pgm` for program, `arr_sel_mass` for erase) is high for at least T_SEL_US before `arr_hv_en` rises.
- R2: In program mode, the first `arr_we` pulse starts at least T_HVW_US after `arr_hv_en` rises.
- R3: Each accepted byte gives one `arr_we` pulse of exactly T_PROG_US, with `arr_addr` and `arr_data` holding that byte. Several bytes may follow one another inside one high-voltage window. The window closes after the byte marked `wr_last`.
- R4: After `arr_hv_en` falls, `arr_sel_pgm` stays high for at least T_PHOLD_US and `arr_sel_mass` stays high for at least T_MHOLD_US.
- R5: `busy` stays high for at least T_REC_US after the select line drops. `done` then pulses for one cycle as `busy` falls. While `busy` is low, no select and no high-voltage enable is active.
- R6: In erase mode, `arr_hv_en` stays high for at least T_MASS_US, and no `arr_we` pulse occurs.
- R7: A byte whose row program-time total plus T_PROG_US would exceed BUDGET_US is refused: no `arr_we` pulse, and `viol` is set.
- R8: A byte whose address has already been programmed twice since the last completed erase is refused: no `arr_we` pulse, and `viol` is set. A completed erase makes every address and row programmable again.
- R9: A `cmd_start` that arrives while `busy` is high is ignored. Its mode has no effect on the running operation.
- R10: A byte whose row (address bits above ROW_W) differs from the row of the first byte in the window gets no write. It ends the window and sets `row_err`.
- R11: After reset, all array strobes, `busy`, `done`, `wr_ready`, `viol` and `row_err` are low.
- R12: An accepted `cmd_start` clears `viol` and `row_err`. After a refused byte that is not marked last, the window stays open for further bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start pulse, taken only when idle |
| cmd_erase | input | 1 | Mode with start: 1 erase, 0 program |
| wr_valid | input | 1 | Program byte offered |
| wr_addr | input | ADDR_W | Byte address |
| wr_data | input | DATA_W | Byte value |
| wr_last | input | 1 | This byte closes the window |
| wr_ready | output | 1 | Sequencer can take a byte this cycle |
| arr_sel_pgm | output | 1 | Array program select |
| arr_sel_mass | output | 1 | Array erase select |
| arr_hv_en | output | 1 | High-voltage enable |
| arr_we | output | 1 | Byte write strobe |
| arr_addr | output | ADDR_W | Address during the strobe |
| arr_data | output | DATA_W | Data during the strobe |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| viol | output | 1 | A byte was refused for wear |
| row_err | output | 1 | A byte fell outside the window row |

## Verification
The stimulus covers a clean three-byte program burst, which shows the ordering of select, enable and strobes, and a start pulse in the opposite mode during a run, which shows whether the request was ignored. A repeated address tells the count limit apart from the time budget, because it is refused while a fresh address in the same row is still written. A fourth row entry that crosses the budget shows refusal by time alone. A byte in a foreign row shows that the window ends rather than skipping the byte. A final erase followed by rewriting the worn addresses shows that the counts and totals were cleared.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_HVLEAD, ST_BYTEWAIT, ST_BYTEPROG, ST_HOLD, ST_RECOV
  } seq_state_t;

  // microseconds to a whole, non-zero number of clock cycles
  function automatic int us_to_cyc(input int cyc_per_us, input int us);
    int r;
    r = cyc_per_us * us;
    return (r < 1) ? 1 : r;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // true when one more program period keeps the row inside its budget
  function automatic logic budget_ok(input int acc_us, input int add_us, input int lim_us);
    return (acc_us + add_us) <= lim_us;
  endfunction

endpackage

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/flash_wear_table.sv
module flash_wear_table #(
  parameter int ADDR_W  = 9,
  parameter int ROW_W   = 6,
  parameter int ACC_W   = 13,
  parameter int PROG_US = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bump,
  input  logic [ADDR_W-1:0] bump_addr,
  input  logic [ADDR_W-1:0] q_addr,
  output logic [1:0]        q_cnt,
  output logic [ACC_W-1:0]  q_acc
);
  localparam int NADDR = 1 << ADDR_W;
  localparam int NROW  = 1 << (ADDR_W - ROW_W);
  localparam int RIX_W = ADDR_W - ROW_W;

  logic [1:0]       cnt_q [NADDR];
  logic [ACC_W-1:0] acc_q [NROW];
  logic [RIX_W-1:0] bump_row;

  assign bump_row = bump_addr[ADDR_W-1:ROW_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NADDR; i++) cnt_q[i] <= '0;
      for (int j = 0; j < NROW; j++)  acc_q[j] <= '0;
    end else if (clr) begin
      for (int i = 0; i < NADDR; i++) cnt_q[i] <= '0;
      for (int j = 0; j < NROW; j++)  acc_q[j] <= '0;
    end else if (bump) begin
      if (cnt_q[bump_addr] != 2'd3) cnt_q[bump_addr] <= cnt_q[bump_addr] + 2'd1;
      acc_q[bump_row] <= acc_q[bump_row] + ACC_W'(PROG_US);
    end
  end

  assign q_cnt = cnt_q[q_addr];
  assign q_acc = acc_q[q_addr[ADDR_W-1:ROW_W]];
endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int ROW_W       = 6,
  parameter int DATA_W      = 8,
  parameter int CYC_PER_US  = 20,
  parameter int T_SEL_US    = 5,
  parameter int T_HVW_US    = 10,
  parameter int T_PROG_US   = 30,
  parameter int T_PHOLD_US  = 5,
  parameter int T_MHOLD_US  = 100,
  parameter int T_REC_US    = 1,
  parameter int T_MASS_US   = 500000,
  parameter int BUDGET_US   = 8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_erase,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_last,
  output logic              wr_ready,
  output logic              arr_sel_pgm,
  output logic              arr_sel_mass,
  output logic              arr_hv_en,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic              busy,
  output logic              done,
  output logic              viol,
  output logic              row_err
);
  localparam int RIX_W   = ADDR_W - ROW_W;
  localparam int N_SEL   = us_to_cyc(CYC_PER_US, T_SEL_US);
  localparam int N_HVW   = us_to_cyc(CYC_PER_US, T_HVW_US);
  localparam int N_PROG  = us_to_cyc(CYC_PER_US, T_PROG_US);
  localparam int N_PHOLD = us_to_cyc(CYC_PER_US, T_PHOLD_US);
  localparam int N_MHOLD = us_to_cyc(CYC_PER_US, T_MHOLD_US);
  localparam int N_REC   = us_to_cyc(CYC_PER_US, T_REC_US);
  localparam int N_MASS  = us_to_cyc(CYC_PER_US, T_MASS_US);
  localparam int MAXC    = max_of(max_of(max_of(N_SEL, N_HVW), max_of(N_PROG, N_PHOLD)),
                                  max_of(max_of(N_MHOLD, N_REC), N_MASS));
  localparam int CW      = $clog2(MAXC + 1);
  localparam int ACC_W   = $clog2(BUDGET_US + 1);
  localparam logic [CW-1:0] L_SEL   = CW'(N_SEL - 1);
  localparam logic [CW-1:0] L_HVW   = CW'(N_HVW - 1);
  localparam logic [CW-1:0] L_PROG  = CW'(N_PROG - 1);
  localparam logic [CW-1:0] L_PHOLD = CW'(N_PHOLD - 1);
  localparam logic [CW-1:0] L_MHOLD = CW'(N_MHOLD - 1);
  localparam logic [CW-1:0] L_REC   = CW'(N_REC - 1);
  localparam logic [CW-1:0] L_MASS  = CW'(N_MASS - 1);

  seq_state_t        state_q, state_d;
  logic              mode_q, last_q, row_set_q, viol_q, err_q, done_q;
  logic [RIX_W-1:0]  row_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              tmr_ld, tmr_exp;
  logic [CW-1:0]     tmr_val;
  logic [1:0]        q_cnt;
  logic [ACC_W-1:0]  q_acc;

  // named internal events
  logic ev_start, ev_take, in_row, cnt_full, budget_fail;
  logic ev_row_bad, ev_refuse, ev_prog, erase_done;

  assign ev_start    = cmd_start && (state_q == ST_IDLE);
  assign ev_take     = wr_valid && (state_q == ST_BYTEWAIT);
  assign in_row      = !row_set_q || (wr_addr[ADDR_W-1:ROW_W] == row_q);
  assign cnt_full    = (q_cnt >= 2'd2);
  assign budget_fail = !budget_ok(int'(q_acc), T_PROG_US, BUDGET_US);
  assign ev_row_bad  = ev_take && !in_row;
  assign ev_refuse   = ev_take && in_row && (cnt_full || budget_fail);
  assign ev_prog     = ev_take && in_row && !cnt_full && !budget_fail;
  assign erase_done  = (state_q == ST_HVLEAD) && mode_q && tmr_exp;

  flash_seq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_ld), .load_val(tmr_val), .expired(tmr_exp));

  flash_wear_table #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .ACC_W(ACC_W), .PROG_US(T_PROG_US)) u_wear (
    .clk(clk), .rst_n(rst_n), .clr(erase_done), .bump(ev_prog), .bump_addr(wr_addr),
    .q_addr(wr_addr), .q_cnt(q_cnt), .q_acc(q_acc));

  always_comb begin
    state_d = state_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    unique case (state_q)
      ST_IDLE:
        if (cmd_start) begin state_d = ST_SETUP; tmr_ld = 1'b1; tmr_val = L_SEL; end
      ST_SETUP:
        if (tmr_exp) begin
          state_d = ST_HVLEAD; tmr_ld = 1'b1; tmr_val = mode_q ? L_MASS : L_HVW;
        end
      ST_HVLEAD:
        if (tmr_exp) begin
          if (mode_q) begin state_d = ST_HOLD; tmr_ld = 1'b1; tmr_val = L_MHOLD; end
          else state_d = ST_BYTEWAIT;
        end
      ST_BYTEWAIT:
        if (ev_row_bad || (ev_refuse && wr_last)) begin
          state_d = ST_HOLD; tmr_ld = 1'b1; tmr_val = L_PHOLD;
        end else if (ev_prog) begin
          state_d = ST_BYTEPROG; tmr_ld = 1'b1; tmr_val = L_PROG;
        end
      ST_BYTEPROG:
        if (tmr_exp) begin
          if (last_q) begin state_d = ST_HOLD; tmr_ld = 1'b1; tmr_val = L_PHOLD; end
          else state_d = ST_BYTEWAIT;
        end
      ST_HOLD:
        if (tmr_exp) begin state_d = ST_RECOV; tmr_ld = 1'b1; tmr_val = L_REC; end
      ST_RECOV:
        if (tmr_exp) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; mode_q <= 1'b0; last_q <= 1'b0; row_set_q <= 1'b0;
      row_q <= '0; addr_q <= '0; data_q <= '0;
      viol_q <= 1'b0; err_q <= 1'b0; done_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_RECOV) && tmr_exp;
      if (ev_start) begin
        mode_q <= cmd_erase; viol_q <= 1'b0; err_q <= 1'b0;
        row_set_q <= 1'b0; last_q <= 1'b0;
      end
      if (ev_take && in_row) begin
        row_q <= wr_addr[ADDR_W-1:ROW_W]; row_set_q <= 1'b1;
      end
      if (ev_row_bad) err_q  <= 1'b1;
      if (ev_refuse)  viol_q <= 1'b1;
      if (ev_prog) begin
        addr_q <= wr_addr; data_q <= wr_data; last_q <= wr_last;
      end
    end
  end

  logic active;
  assign active       = (state_q != ST_IDLE) && (state_q != ST_RECOV);
  assign arr_sel_pgm  = active && !mode_q;
  assign arr_sel_mass = active && mode_q;
  assign arr_hv_en    = (state_q == ST_HVLEAD) || (state_q == ST_BYTEWAIT) || (state_q == ST_BYTEPROG);
  assign arr_we       = (state_q == ST_BYTEPROG);
  assign arr_addr     = addr_q;
  assign arr_data     = data_q;
  assign wr_ready     = (state_q == ST_BYTEWAIT);
  assign busy         = (state_q != ST_IDLE);
  assign done         = done_q;
  assign viol         = viol_q;
  assign row_err      = err_q;

  // ---------------- assertion helpers: interval age counters ----------------
  localparam logic [CW-1:0] SAT = {CW{1'b1}};
  localparam logic [CW-1:0] K_SEL   = CW'(N_SEL);
  localparam logic [CW-1:0] K_HVW   = CW'(N_HVW);
  localparam logic [CW-1:0] K_PHOLD = CW'(N_PHOLD);
  localparam logic [CW-1:0] K_MHOLD = CW'(N_MHOLD);
  localparam logic [CW-1:0] K_MASS  = CW'(N_MASS);
  localparam logic [CW-1:0] K_PROG  = CW'(N_PROG);
  logic [CW-1:0] sel_age, hv_age, off_age, we_age;
  logic any_sel;
  assign any_sel = arr_sel_pgm || arr_sel_mass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_age <= '0; hv_age <= '0; off_age <= '0; we_age <= '0;
    end else begin
      sel_age <= !any_sel ? '0 : (sel_age == SAT ? SAT : sel_age + 1'b1);
      hv_age  <= !arr_hv_en ? '0 : (hv_age == SAT ? SAT : hv_age + 1'b1);
      off_age <= (!any_sel || arr_hv_en) ? '0 : (off_age == SAT ? SAT : off_age + 1'b1);
      we_age  <= !arr_we ? '0 : (we_age == SAT ? SAT : we_age + 1'b1);
    end
  end

  a_r1_sel_lead: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arr_hv_en) |-> sel_age >= K_SEL);
  a_r2_hv_lead: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arr_we) |-> hv_age >= K_HVW);
  a_r3_we_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (arr_hv_en && arr_sel_pgm));
  a_r3_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arr_we) |-> we_age == K_PROG);
  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |-> ($stable(arr_addr) && $stable(arr_data)));
  a_r4_pgm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arr_sel_pgm) |-> off_age >= K_PHOLD);
  a_r4_mass_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arr_sel_mass) |-> off_age >= K_MHOLD);
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(arr_sel_pgm || arr_sel_mass || arr_hv_en || arr_we));
  a_r6_mass_hv: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(arr_hv_en) && arr_sel_mass) |-> hv_age >= K_MASS);
  a_r9_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_sel_pgm, arr_sel_mass}));
endmodule

// File: tb/test_flash_pe_seq.sv
module test_flash_pe_seq;
  localparam int ADDR_W = 9, ROW_W = 6, DATA_W = 8;
  localparam int CPU = 2;
  localparam int E_SEL = 10, E_HVW = 20, E_PROG = 60, E_PHOLD = 10;
  localparam int E_MHOLD = 200, E_REC = 2, E_MASS = 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 0, cmd_erase = 0, wr_valid = 0, wr_last = 0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic wr_ready, arr_sel_pgm, arr_sel_mass, arr_hv_en, arr_we, busy, done, viol, row_err;
  logic [ADDR_W-1:0] arr_addr;
  logic [DATA_W-1:0] arr_data;

  always #2 clk = ~clk;

  flash_pe_seq #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .DATA_W(DATA_W), .CYC_PER_US(CPU),
    .T_SEL_US(5), .T_HVW_US(10), .T_PROG_US(30), .T_PHOLD_US(5), .T_MHOLD_US(100),
    .T_REC_US(1), .T_MASS_US(500), .BUDGET_US(200)) i_flash_pe_seq (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_erase(cmd_erase),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_last(wr_last),
    .wr_ready(wr_ready), .arr_sel_pgm(arr_sel_pgm), .arr_sel_mass(arr_sel_mass),
    .arr_hv_en(arr_hv_en), .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data),
    .busy(busy), .done(done), .viol(viol), .row_err(row_err));

  int total = 0, bad = 0;

  // ---------------- negedge monitor ----------------
  int cyc = 0;
  int t_sel_rise, t_hv_rise, t_hv_fall, t_sel_fall, t_busy_fall, t_first_we, t_we_rise;
  int we_cnt, we_wmin, we_wmax, done_cnt, first_addr, first_data;
  bit saw_mass, saw_pgm;
  logic p_sel = 0, p_hv = 0, p_we = 0, p_busy = 0;

  task automatic clear_mon();
    t_sel_rise = -1; t_hv_rise = -1; t_hv_fall = -1; t_sel_fall = -1; t_busy_fall = -1;
    t_first_we = -1; t_we_rise = -1; we_cnt = 0; we_wmin = 1 << 30; we_wmax = 0;
    done_cnt = 0; first_addr = -1; first_data = -1; saw_mass = 0; saw_pgm = 0;
  endtask

  always @(negedge clk) begin
    logic s;
    cyc++;
    s = arr_sel_pgm | arr_sel_mass;
    if (s && !p_sel) t_sel_rise = cyc;
    if (!s && p_sel) t_sel_fall = cyc;
    if (arr_hv_en && !p_hv) t_hv_rise = cyc;
    if (!arr_hv_en && p_hv) t_hv_fall = cyc;
    if (arr_we && !p_we) begin
      t_we_rise = cyc; we_cnt++;
      if (t_first_we < 0) begin
        t_first_we = cyc; first_addr = int'(arr_addr); first_data = int'(arr_data);
      end
    end
    if (!arr_we && p_we) begin
      if (cyc - t_we_rise < we_wmin) we_wmin = cyc - t_we_rise;
      if (cyc - t_we_rise > we_wmax) we_wmax = cyc - t_we_rise;
    end
    if (!busy && p_busy) t_busy_fall = cyc;
    if (done) done_cnt++;
    if (arr_sel_mass) saw_mass = 1;
    if (arr_sel_pgm) saw_pgm = 1;
    p_sel = s; p_hv = arr_hv_en; p_we = arr_we; p_busy = busy;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start_op(input bit erase);
    @(negedge clk); cmd_start = 1; cmd_erase = erase;
    @(negedge clk); cmd_start = 0; cmd_erase = 0;
  endtask

  task automatic send_byte(input int a, input int d, input bit last);
    int n = 0;
    while (!wr_ready && n < 5000) begin @(negedge clk); n++; end
    wr_valid = 1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d); wr_last = last;
    @(negedge clk); wr_valid = 0; wr_last = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(!busy && !done && !wr_ready, "R11 busy/done/ready after reset",
        int'({busy, done, wr_ready}), 0);
    chk(!arr_sel_pgm && !arr_sel_mass && !arr_hv_en && !arr_we, "R11 strobes after reset",
        int'({arr_sel_pgm, arr_sel_mass, arr_hv_en, arr_we}), 0);
    chk(!viol && !row_err, "R11 flags after reset", int'({viol, row_err}), 0);
  endtask

  task automatic t_burst();
    clear_mon();
    start_op(0);
    send_byte(5, 'hA5, 0); send_byte(6, 'h3C, 0); send_byte(7, 'h81, 1);
    wait_idle();
    chk(t_hv_rise - t_sel_rise >= E_SEL, "R1 select lead", t_hv_rise - t_sel_rise, E_SEL);
    chk(t_first_we - t_hv_rise >= E_HVW, "R2 enable lead", t_first_we - t_hv_rise, E_HVW);
    chk(we_cnt == 3, "R3 strobe count", we_cnt, 3);
    chk(we_wmin == E_PROG && we_wmax == E_PROG, "R3 strobe width", we_wmax, E_PROG);
    chk(first_addr == 5 && first_data == 'hA5, "R3 first byte addr", first_addr, 5);
    chk(t_sel_fall - t_hv_fall >= E_PHOLD, "R4 program hold", t_sel_fall - t_hv_fall, E_PHOLD);
    chk(t_busy_fall - t_sel_fall >= E_REC, "R5 recovery", t_busy_fall - t_sel_fall, E_REC);
    chk(done_cnt == 1, "R5 done pulse", done_cnt, 1);
    chk(!viol && !row_err, "R7 no refusal in budget", int'({viol, row_err}), 0);
  endtask

  task automatic t_busy_start();
    clear_mon();
    start_op(0);
    start_op(1);
    start_op(1);
    send_byte(5, 'h11, 1);
    wait_idle();
    chk(!saw_mass && saw_pgm, "R9 erase start ignored while busy", int'(saw_mass), 0);
    chk(we_cnt == 1, "R9 run unchanged", we_cnt, 1);
    chk(done_cnt == 1, "R9 single completion", done_cnt, 1);
    chk(!viol, "R8 second program allowed", int'(viol), 0);
  endtask

  task automatic t_third_write();
    clear_mon();
    start_op(0);
    send_byte(5, 'h22, 0);
    send_byte(8, 'h44, 1);
    wait_idle();
    chk(viol, "R8 third program refused flag", int'(viol), 1);
    chk(we_cnt == 1 && first_addr == 8, "R8 only fresh address written", first_addr, 8);
    chk(we_cnt == 1, "R12 window stays open after refusal", we_cnt, 1);
  endtask

  task automatic t_budget();
    clear_mon();
    start_op(0);
    repeat (4) @(negedge clk);
    chk(!viol, "R12 flag cleared by start", int'(viol), 0);
    send_byte(9, 'h55, 0);
    send_byte(10, 'h66, 1);
    wait_idle();
    chk(viol, "R7 budget refusal flag", int'(viol), 1);
    chk(we_cnt == 1 && first_addr == 9, "R7 only in-budget byte written", we_cnt, 1);
    chk(done_cnt == 1, "R7 window closed on last", done_cnt, 1);
  endtask

  task automatic t_row();
    clear_mon();
    start_op(0);
    send_byte(64, 'h77, 0);
    send_byte(3, 'h99, 0);
    wait_idle();
    chk(row_err, "R10 row error flag", int'(row_err), 1);
    chk(we_cnt == 1 && first_addr == 64, "R10 foreign byte not written", we_cnt, 1);
    chk(done_cnt == 1, "R10 window ended", done_cnt, 1);
  endtask

  task automatic t_erase();
    clear_mon();
    start_op(1);
    wait_idle();
    chk(t_hv_rise - t_sel_rise >= E_SEL, "R1 erase select lead", t_hv_rise - t_sel_rise, E_SEL);
    chk(t_hv_fall - t_hv_rise >= E_MASS, "R6 erase enable time", t_hv_fall - t_hv_rise, E_MASS);
    chk(we_cnt == 0, "R6 no strobe in erase", we_cnt, 0);
    chk(t_sel_fall - t_hv_fall >= E_MHOLD, "R4 erase hold", t_sel_fall - t_hv_fall, E_MHOLD);
    chk(!row_err && !viol && done_cnt == 1, "R12 erase clears flags", int'({viol, row_err}), 0);
    clear_mon();
    start_op(0);
    send_byte(5, 'h01, 0); send_byte(10, 'h02, 1);
    wait_idle();
    chk(we_cnt == 2 && !viol, "R8 counts and budget cleared by erase", we_cnt, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_burst();
    t_busy_start();
    t_third_write();
    t_budget();
    t_row();
    t_erase();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule